// File: doc/BRIEF.md
# FIFO-Driven Bus Interrupter with Release on Read

This block raises a bus interrupt request from the fill state of an output FIFO. Software programs one 16-bit interrupt register with three fields: a request level from 0 to 7, a source select, and an 8-bit status/ID byte. The source select chooses between two triggers: the FIFO being at least half full, or the FIFO holding any data. While the chosen condition holds, the block pulls low the one request line whose number equals the programmed level.

When the bus master runs an interrupt-acknowledge cycle for that level, the block answers with the status/ID byte on the low data byte. The acknowledge does not clear the request. The request is only withdrawn after FIFO reads have drained the FIFO enough that the trigger condition no longer holds. An acknowledge for another level, or one that arrives while no request is pending, is passed on to the next device. Arbitration and daisy-chain wiring outside the block belong to the system.

Top module: `rora_interrupter`

## Requirements
- R1: The register reads back as {level[15:13], source[12], 4'b1111 in bits 11..8, status/ID[7:0]}, so writing 16'hA5C3 reads back as 16'hAFC3.
- R2: With source 0, a request is raised while the half-full flag is 1, and not while only the not-empty condition holds.
- R3: With source 1, a request is raised while the FIFO is not empty (empty flag 0).
- R4: A raised request drives irq_n[level] low (line numbers 1..7) and holds every other line high; at most one line is ever low.
- R5: A level of 0 keeps every request line high, whatever the FIFO state.
- R6: An acknowledge does not clear a request. A raised request is withdrawn only when the trigger condition is false and at least one FIFO read strobe has been seen since it was raised. If the condition goes false with no read, the request stays.
- R7: While iack is high with iack_level equal to the programmed level and a request is pending, the next cycle has vec_valid = 1 and vec_data = status/ID.
- R8: An acknowledge at another level, or one with no request pending, gives iack_pass = 1 and vec_valid = 0 in the next cycle.
- R9: Reset sets the register to level 0, source 0 and status/ID 0, so it reads back as 16'h0F00, and all request lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the interrupt register |
| cfg_wdata | input | 16 | Write data for the interrupt register |
| cfg_rdata | output | 16 | Interrupt register read-back |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_half | input | 1 | FIFO at or above half full |
| fifo_rd | input | 1 | One-cycle strobe for each FIFO read |
| iack | input | 1 | Interrupt-acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| irq_n | output | 7 | Active-low request lines 1..7 (bit 0 = line 1) |
| vec_valid | output | 1 | Status/ID byte is being driven |
| vec_data | output | 8 | Status/ID byte |
| iack_pass | output | 1 | Acknowledge not claimed; pass it on |

## Verification
The bench builds the block with its default parameters: seven request lines, a 3-bit level and an 8-bit status/ID. With these values it can reach both ends of the level range. It checks level 0, which disables the request, and level 7, the top line. It also uses a middle level to catch an off-by-one in the line decode. Changing the level while a request is pending shows that only one line moves, and the release cases separate draining with a read from the flag falling without any read.

// File: rtl/rora_pkg.sv
package rora_pkg;
  localparam int REG_W   = 16;
  localparam int LVL_W   = 3;
  localparam int ID_W    = 8;
  localparam int LVL_LSB = 13;
  localparam int SRC_BIT = 12;
  localparam int NLINES  = (1 << LVL_W) - 1;

  typedef struct packed {
    logic [LVL_W-1:0] level;
    logic             src_ne;
    logic [ID_W-1:0]  status;
  } irq_cfg_t;
endpackage

// File: rtl/rora_cfg_reg.sv
module rora_cfg_reg
  import rora_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output irq_cfg_t         cfg
);
  localparam int PAD_W = SRC_BIT - ID_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr) begin
      cfg.level  <= wdata[LVL_LSB +: LVL_W];
      cfg.src_ne <= wdata[SRC_BIT];
      cfg.status <= wdata[ID_W-1:0];
    end
  end

  assign rdata = {cfg.level, cfg.src_ne, {PAD_W{1'b1}}, cfg.status};

  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (cfg.level == '0 && !cfg.src_ne));
endmodule

// File: rtl/rora_req_gen.sv
module rora_req_gen
  import rora_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  irq_cfg_t          cfg,
  input  logic              fifo_empty,
  input  logic              fifo_half,
  input  logic              fifo_rd,
  output logic              req_active,
  output logic [NLINES-1:0] irq_n
);
  logic cond, lvl_nz, req_q, rd_seen, req_next;

  assign lvl_nz   = (cfg.level != '0);
  assign cond     = cfg.src_ne ? !fifo_empty : fifo_half;
  assign req_next = lvl_nz && (cond || (req_q && !rd_seen));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      rd_seen <= 1'b0;
    end else begin
      req_q   <= req_next;
      rd_seen <= req_next && (rd_seen || (req_q && fifo_rd));
    end
  end

  assign req_active = req_q;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_n[i] <= 1'b1;
      else     irq_n[i] <= !(req_q && lvl_nz && (cfg.level == LVL_W'(i + 1)));
    end
  end

  p_onehot_line_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~irq_n));
  p_level_zero_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg.level == '0) |=> (&irq_n));
  p_release_needs_drain_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(req_q) && $past(lvl_nz)) |-> !$past(cond));
endmodule

// File: rtl/rora_ack_resp.sv
module rora_ack_resp
  import rora_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  irq_cfg_t         cfg,
  input  logic             req_active,
  input  logic             iack,
  input  logic [LVL_W-1:0] iack_level,
  output logic             vec_valid,
  output logic [ID_W-1:0]  vec_data,
  output logic             iack_pass
);
  logic claim;
  assign claim = iack && req_active && (cfg.level != '0) && (iack_level == cfg.level);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
      iack_pass <= 1'b0;
    end else begin
      vec_valid <= claim;
      vec_data  <= claim ? cfg.status : '0;
      iack_pass <= iack && !claim;
    end
  end

  p_vector_on_match_r7: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(iack) && $past(iack_level) == $past(cfg.level)));
  p_pass_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(vec_valid && iack_pass));
endmodule

// File: rtl/rora_interrupter.sv
module rora_interrupter
  import rora_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              fifo_empty,
  input  logic              fifo_half,
  input  logic              fifo_rd,
  input  logic              iack,
  input  logic [2:0]        iack_level,
  output logic [6:0]        irq_n,
  output logic              vec_valid,
  output logic [7:0]        vec_data,
  output logic              iack_pass
);
  irq_cfg_t cfg;
  logic     req_active;

  rora_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  rora_req_gen u_req (
    .clk(clk), .rst(rst), .cfg(cfg), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half), .fifo_rd(fifo_rd),
    .req_active(req_active), .irq_n(irq_n)
  );

  rora_ack_resp u_ack (
    .clk(clk), .rst(rst), .cfg(cfg), .req_active(req_active),
    .iack(iack), .iack_level(iack_level), .vec_valid(vec_valid),
    .vec_data(vec_data), .iack_pass(iack_pass)
  );
endmodule

// File: tb/rora_interrupter_bench.sv
module rora_interrupter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        fifo_empty = 1'b1, fifo_half = 1'b0, fifo_rd = 1'b0;
  logic        iack = 1'b0;
  logic [2:0]  iack_level = '0;
  logic [6:0]  irq_n;
  logic        vec_valid, iack_pass;
  logic [7:0]  vec_data;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rora_interrupter u_rora_interrupter (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FIFO check FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] w);
    cfg_wr = 1'b1; cfg_wdata = w; tick(1); cfg_wr = 1'b0;
  endtask

  function automatic logic [6:0] line(input int lvl);
    return (lvl == 0) ? 7'h7F : ~(7'h01 << (lvl - 1));
  endfunction

  task automatic t_reset;
    rst = 1'b1; fifo_empty = 1'b1; fifo_half = 1'b0; tick(2); rst = 1'b0; tick(1);
    chk("R9 readback", cfg_rdata, 16'h0F00);
    chk("R9 lines", irq_n, 7'h7F);
  endtask

  task automatic t_readback;
    wr(16'hA5C3); chk("R1 readback", cfg_rdata, 16'hAFC3);
  endtask

  task automatic t_halffull;
    wr(16'h6011);                        // level 3, source 0
    fifo_empty = 1'b0; fifo_half = 1'b0; tick(3);
    chk("R2 not-empty only", irq_n, 7'h7F);
    fifo_half = 1'b1; tick(3);
    chk("R2 half raised", irq_n, line(3));
    fifo_rd = 1'b1; fifo_half = 1'b0; tick(1); fifo_rd = 1'b0; fifo_empty = 1'b1; tick(3);
    chk("R6 drained", irq_n, 7'h7F);
  endtask

  task automatic t_notempty_level;
    wr(16'hF022);                        // level 7, source 1
    fifo_empty = 1'b0; tick(3);
    chk("R3 raised", irq_n, line(7));
    chk("R4 top line", irq_n[6], 1'b0);
    wr(16'h5022);                        // level 2 while pending
    tick(2);
    chk("R4 moved line", irq_n, line(2));
  endtask

  task automatic t_level0;
    wr(16'h1022); tick(3);
    chk("R5 disabled", irq_n, 7'h7F);
    iack = 1'b1; iack_level = 3'd0; tick(1);
    chk("R8 level0 pass", {vec_valid, iack_pass}, 2'b01);
    iack = 1'b0; tick(1);
  endtask

  task automatic t_ack;
    wr(16'h9077);                        // level 4, source 1, id 77
    tick(3);
    iack = 1'b1; iack_level = 3'd4; tick(1);
    chk("R7 vector valid", vec_valid, 1'b1);
    chk("R7 vector data", vec_data, 8'h77);
    iack = 1'b0; tick(3);
    chk("R6 ack keeps request", irq_n, line(4));
    iack = 1'b1; iack_level = 3'd5; tick(1);
    chk("R8 mismatch", {vec_valid, iack_pass}, 2'b01);
    iack = 1'b0; tick(1);
  endtask

  task automatic t_release;
    fifo_empty = 1'b1; tick(4);
    chk("R6 no read holds", irq_n, line(4));
    fifo_rd = 1'b1; tick(1); fifo_rd = 1'b0; tick(3);
    chk("R6 read releases", irq_n, 7'h7F);
    iack = 1'b1; iack_level = 3'd4; tick(1);
    chk("R8 no request pass", {vec_valid, iack_pass}, 2'b01);
    iack = 1'b0; tick(1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_readback(); t_halffull(); t_notempty_level();
        t_level0(); t_ack(); t_release(); t_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule